// File: doc/BRIEF.md
# Power Mode Controller FSM

This block is the control sequencer of a supply-and-bus interface chip. It walks the chip through six operating modes (Shutdown, Reset, Standby, Normal, Sleep and Thermal Shutdown). Its inputs are digitised comparator flags for the battery supply, for regulator undervoltage and for over-temperature, together with the asynchronous enable and transmit-data pins driven by the host microcontroller and a wakeup pulse from the bus receiver. From these it drives the regulator enable, the active-low reset pin, the bus transceiver mode and the source of the receive-data pin.

Every timing window is a counter of clock ticks set by a parameter: the reset pulse, the undervoltage filter and the mode-selection delay. The host chooses its low-power mode by dropping the enable pin. The level of the transmit-data pin a fixed delay later selects Standby (high) or Sleep (low). A fixed-length reset pulse is inserted on every exit from Shutdown, Thermal Shutdown or Sleep, and after any filtered regulator undervoltage. When that pulse ends, the enable pin selects Normal or Standby.

All ports are plain control and status pins. No data stream passes through the block, so no valid/ready handshake and no back-pressure rules apply.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `vs_below_off` is 1, the outputs take Shutdown values in the same cycle: `vreg_en`=0, `rstn_o`=0, `lin_mode`=00 and `rxd_sel`=00. From the next edge the mode is Shutdown, which is also the mode after `rst_n`. Shutdown is left, always to Reset, only on an edge where `vs_above_on`=1 and `over_temp`=0.
- R2: In Reset, `vreg_en`=1, `rstn_o`=0 and `lin_mode`=01 (Wakeup).
- R3: `over_temp`=1 forces Thermal Shutdown from every mode except Shutdown, with `vreg_en`=0, `rstn_o`=0 and `lin_mode`=01. The first edge with `over_temp`=0 moves the machine to Reset.
- R4: Reset lasts exactly RESET_TICKS edges during which `vreg_uv`=0. Any edge with `vreg_uv`=1 restarts that count. Reset then moves to Normal if the synchronised enable is 1, and to Standby if it is 0.
- R5: In Standby a synchronised enable of 1 moves the machine to Normal.
- R6: In Normal, a falling edge of `en_pin` reaches the machine after SYNC_STAGES+1 edges and starts a window of MODESEL_TICKS edges. At the end of that window the synchronised `txd_pin` is sampled: 1 selects Standby and 0 selects Sleep. If the enable returns high inside the window, the machine stays in Normal.
- R7: In Sleep, `vreg_en`=0 and `rstn_o`=0. Either `lin_wake`=1 or a synchronised enable of 1 moves the machine to Reset.
- R8: In Standby or Normal, `vreg_uv` held for UV_FILT_TICKS consecutive edges forces Reset. A shorter run has no effect on the outputs.
- R9: `lin_mode` is 10 (Active) only in Normal, 00 (Off) only in Shutdown, and 01 (Wakeup) in every other mode. `rstn_o` is 1 only in Standby and Normal.
- R10: `rxd_sel` is 10 (bus data) in Normal and 00 (pulled high) in Shutdown and Sleep. In Reset, Standby and Thermal Shutdown it is 01 (driven low) once a `lin_wake` has been seen in a Wakeup-mode state, and 00 otherwise. That indication is cleared only by entering Normal or Shutdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vs_above_on | input | 1 | Supply above the high power-on threshold |
| vs_below_off | input | 1 | Supply below the low power-off threshold |
| vreg_uv | input | 1 | Regulator output below its undervoltage threshold |
| over_temp | input | 1 | Junction above the thermal shutdown limit |
| en_pin | input | 1 | Asynchronous enable pin from the host |
| txd_pin | input | 1 | Asynchronous transmit-data pin from the host |
| lin_wake | input | 1 | Wakeup detected on the bus |
| vreg_en | output | 1 | Regulator enable |
| rstn_o | output | 1 | Active-low reset to the host |
| lin_mode | output | 2 | Transceiver mode: 00 Off, 01 Wakeup, 10 Active |
| rxd_sel | output | 2 | Receive pin source: 00 pulled high, 01 driven low, 10 bus data |

## Verification
The bench builds the block with RESET_TICKS=8, UV_FILT_TICKS=4, MODESEL_TICKS=3 and SYNC_STAGES=2. With these values every timing window closes within a few tens of cycles. The exact edge on which a mode selection takes effect, an undervoltage run one edge short of the filter against one that trips it, and the exact reset-pulse length can all be checked cycle by cycle. A walk through every mode transition, each held long enough to settle, covers the decode of all six modes.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    MD_OFF     = 3'd0,
    MD_RESET   = 3'd1,
    MD_STANDBY = 3'd2,
    MD_NORMAL  = 3'd3,
    MD_SLEEP   = 3'd4,
    MD_THERMAL = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    LIN_OFF    = 2'b00,
    LIN_WAKE   = 2'b01,
    LIN_ACTIVE = 2'b10
  } lin_mode_e;

  typedef enum logic [1:0] {
    RXD_PULLUP   = 2'b00,
    RXD_WAKE_LOW = 2'b01,
    RXD_BUS      = 2'b10
  } rxd_sel_e;
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= RST_VAL;
        else        sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= {STAGES{RST_VAL}};
        else        sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pmc_tick_timer.sv
module pmc_tick_timer #(
  parameter int TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic done
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (restart)             cnt <= '0;
    else if (run && cnt != LAST)  cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);
endmodule

// File: rtl/pmc_out_decode.sv
module pmc_out_decode
  import pmc_pkg::*;
(
  input  mode_e      state,
  input  logic       wake_flag,
  input  logic       vs_below_off,
  output logic       vreg_en,
  output logic       rstn_o,
  output logic [1:0] lin_mode,
  output logic [1:0] rxd_sel
);
  rxd_sel_e  wake_src;
  lin_mode_e lm;
  rxd_sel_e  rs;

  assign wake_src = wake_flag ? RXD_WAKE_LOW : RXD_PULLUP;

  always_comb begin
    vreg_en = 1'b0;
    rstn_o  = 1'b0;
    lm      = LIN_WAKE;
    rs      = wake_src;
    unique case (state)
      MD_OFF:     begin lm = LIN_OFF; rs = RXD_PULLUP; end
      MD_RESET:   begin vreg_en = 1'b1; end
      MD_STANDBY: begin vreg_en = 1'b1; rstn_o = 1'b1; end
      MD_NORMAL:  begin vreg_en = 1'b1; rstn_o = 1'b1; lm = LIN_ACTIVE; rs = RXD_BUS; end
      MD_SLEEP:   begin rs = RXD_PULLUP; end
      MD_THERMAL: begin end
      default:    begin lm = LIN_OFF; rs = RXD_PULLUP; end
    endcase
    // supply loss overrides the registered mode without waiting for a clock
    if (vs_below_off) begin
      vreg_en = 1'b0;
      rstn_o  = 1'b0;
      lm      = LIN_OFF;
      rs      = RXD_PULLUP;
    end
  end

  assign lin_mode = lm;
  assign rxd_sel  = rs;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int RESET_TICKS   = 5000,
  parameter int UV_FILT_TICKS = 25,
  parameter int MODESEL_TICKS = 30,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vs_above_on,
  input  logic       vs_below_off,
  input  logic       vreg_uv,
  input  logic       over_temp,
  input  logic       en_pin,
  input  logic       txd_pin,
  input  logic       lin_wake,
  output logic       vreg_en,
  output logic       rstn_o,
  output logic [1:0] lin_mode,
  output logic [1:0] rxd_sel
);
  mode_e state, state_nxt;
  logic  en_s, txd_s, en_d, en_fall;
  logic  pending, pending_nxt;
  logic  wake_flag, wake_nxt;
  logic  on_mode, wake_mode;
  logic  uv_restart, uv_trip;
  logic  rst_restart, rst_done;
  logic  sel_restart, sel_done;

  pmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_en_sync (
    .clk(clk), .rst_n(rst_n), .d(en_pin), .q(en_s));
  pmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_txd_sync (
    .clk(clk), .rst_n(rst_n), .d(txd_pin), .q(txd_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_d <= 1'b0;
    else        en_d <= en_s;
  end
  assign en_fall = en_d & ~en_s;

  assign on_mode   = (state == MD_STANDBY) || (state == MD_NORMAL);
  assign wake_mode = (state == MD_RESET) || (state == MD_STANDBY) ||
                     (state == MD_SLEEP) || (state == MD_THERMAL);

  // undervoltage filter: counts consecutive low-regulator edges
  assign uv_restart = !(vreg_uv && on_mode);
  pmc_tick_timer #(.TICKS(UV_FILT_TICKS)) u_uv_tmr (
    .clk(clk), .rst_n(rst_n), .restart(uv_restart), .run(!uv_restart), .done(uv_trip));

  // reset pulse: runs only while the regulator is good
  assign rst_restart = !((state == MD_RESET) && !vreg_uv);
  pmc_tick_timer #(.TICKS(RESET_TICKS)) u_rst_tmr (
    .clk(clk), .rst_n(rst_n), .restart(rst_restart), .run(!rst_restart), .done(rst_done));

  // mode-selection window after an enable falling edge
  assign sel_restart = !pending || en_fall;
  pmc_tick_timer #(.TICKS(MODESEL_TICKS)) u_sel_tmr (
    .clk(clk), .rst_n(rst_n), .restart(sel_restart), .run(!sel_restart), .done(sel_done));

  always_comb begin
    state_nxt = state;
    if (vs_below_off) begin
      state_nxt = MD_OFF;
    end else if (over_temp && state != MD_OFF) begin
      state_nxt = MD_THERMAL;
    end else begin
      unique case (state)
        MD_OFF:     if (vs_above_on && !over_temp) state_nxt = MD_RESET;
        MD_RESET:   if (rst_done) state_nxt = en_s ? MD_NORMAL : MD_STANDBY;
        MD_STANDBY: begin
          if (uv_trip)   state_nxt = MD_RESET;
          else if (en_s) state_nxt = MD_NORMAL;
        end
        MD_NORMAL: begin
          if (uv_trip)                state_nxt = MD_RESET;
          else if (sel_done && !en_s) state_nxt = txd_s ? MD_STANDBY : MD_SLEEP;
        end
        MD_SLEEP:   if (lin_wake || en_s) state_nxt = MD_RESET;
        MD_THERMAL: state_nxt = MD_RESET;
        default:    state_nxt = MD_OFF;
      endcase
    end
  end

  always_comb begin
    pending_nxt = pending;
    if (state_nxt != MD_NORMAL || state != MD_NORMAL) pending_nxt = 1'b0;
    else if (en_s)                                     pending_nxt = 1'b0;
    else if (en_fall)                                  pending_nxt = 1'b1;
  end

  always_comb begin
    wake_nxt = wake_flag;
    if (state == MD_NORMAL || state == MD_OFF) wake_nxt = 1'b0;
    else if (lin_wake && wake_mode)            wake_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= MD_OFF;
      pending   <= 1'b0;
      wake_flag <= 1'b0;
    end else begin
      state     <= state_nxt;
      pending   <= pending_nxt;
      wake_flag <= wake_nxt;
    end
  end

  pmc_out_decode u_dec (
    .state(state), .wake_flag(wake_flag), .vs_below_off(vs_below_off),
    .vreg_en(vreg_en), .rstn_o(rstn_o), .lin_mode(lin_mode), .rxd_sel(rxd_sel));
endmodule

// File: rtl/pmc_checks.sv
module pmc_checks
  import pmc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       vs_below_off,
  input logic       over_temp,
  input logic       lin_wake,
  input logic       vreg_en,
  input logic       rstn_o,
  input logic [1:0] lin_mode,
  input mode_e      state
);
  assert_supply_loss_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vs_below_off |-> (!vreg_en && !rstn_o && lin_mode == 2'b00));

  assert_hot_regulator_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (over_temp && !vs_below_off) |=> !vreg_en);

  assert_release_after_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rstn_o) |-> $past(state) == MD_RESET);

  assert_sleep_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MD_SLEEP && lin_wake && !vs_below_off && !over_temp) |=> state == MD_RESET);

  assert_rstn_needs_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rstn_o |-> vreg_en);

  assert_active_only_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lin_mode == 2'b10) |-> (rstn_o && state == MD_NORMAL));
endmodule

bind pwr_mode_ctrl pmc_checks u_chk (
  .clk(clk), .rst_n(rst_n), .vs_below_off(vs_below_off), .over_temp(over_temp),
  .lin_wake(lin_wake), .vreg_en(vreg_en), .rstn_o(rstn_o), .lin_mode(lin_mode),
  .state(state));

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam int RT = 8;
  localparam int UF = 4;
  localparam int MS = 3;

  // expected {vreg_en, rstn_o, lin_mode, rxd_sel}
  localparam logic [5:0] E_OFF   = 6'b00_00_00;
  localparam logic [5:0] E_RESET = 6'b10_01_00;
  localparam logic [5:0] E_STBY  = 6'b11_01_00;
  localparam logic [5:0] E_STBYW = 6'b11_01_01;
  localparam logic [5:0] E_NORM  = 6'b11_10_10;
  localparam logic [5:0] E_LOWP  = 6'b00_01_00;

  typedef struct packed {
    logic vs_on, vs_off, uv, ot, en, txd, wk;
    logic [7:0] hold;
    logic [5:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,8'd20,E_OFF},   // R1 supply low
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'd20,E_STBY},  // R4 reset then standby
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd20,E_NORM},  // R5
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'd20,E_STBY},  // R6 txd high
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd20,E_NORM},  // R5
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'd20,E_LOWP},  // R6 txd low -> sleep
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'd20,E_STBYW}, // R7 R10 wake
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd20,E_NORM},  // R10 cleared
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'd20,E_LOWP},  // R6 sleep
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'd20,E_NORM},  // R7 en exit
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,8'd20,E_LOWP},  // R3 hot
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd20,E_NORM},  // R3 cooled
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'd20,E_OFF},   // R1
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,8'd20,E_OFF},   // R1 hot blocks exit
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'd20,E_NORM}   // R1 exit
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic vs_above_on = 1'b0, vs_below_off = 1'b0, vreg_uv = 1'b0, over_temp = 1'b0;
  logic en_pin = 1'b0, txd_pin = 1'b1, lin_wake = 1'b0;
  logic vreg_en, rstn_o;
  logic [1:0] lin_mode, rxd_sel;
  int errors = 0, checks = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.RESET_TICKS(RT), .UV_FILT_TICKS(UF), .MODESEL_TICKS(MS), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .vs_above_on(vs_above_on), .vs_below_off(vs_below_off),
    .vreg_uv(vreg_uv), .over_temp(over_temp), .en_pin(en_pin), .txd_pin(txd_pin),
    .lin_wake(lin_wake), .vreg_en(vreg_en), .rstn_o(rstn_o), .lin_mode(lin_mode),
    .rxd_sel(rxd_sel));

  function automatic logic [5:0] outs();
    return {vreg_en, rstn_o, lin_mode, rxd_sel};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset state", outs(), E_OFF);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      vs_above_on = VEC[v].vs_on;  vs_below_off = VEC[v].vs_off;
      vreg_uv = VEC[v].uv;  over_temp = VEC[v].ot;
      en_pin = VEC[v].en;  txd_pin = VEC[v].txd;  lin_wake = VEC[v].wk;
      cyc(int'(VEC[v].hold));
      chk($sformatf("vector %0d (R1..R10)", v), outs(), VEC[v].exp);
    end

    // R6 exact selection edge: Normal for 2+1+MS-1 edges, then Standby
    en_pin = 1'b0; txd_pin = 1'b1;
    cyc(2 + MS);
    chk("R6 still normal", outs(), E_NORM);
    cyc(1);
    chk("R6 standby at window end", outs(), E_STBY);

    // R6 enable glitch shorter than the window keeps Normal
    en_pin = 1'b1; cyc(10);
    en_pin = 1'b0; cyc(1);
    en_pin = 1'b1; cyc(20);
    chk("R6 glitch ignored", outs(), E_NORM);

    // R8 short undervoltage ignored, full-length one trips
    vreg_uv = 1'b1; cyc(UF - 1);
    vreg_uv = 1'b0; cyc(1);
    chk("R8 short dip", outs(), E_NORM);
    vreg_uv = 1'b1; cyc(UF);
    chk("R8 trip to reset", outs(), E_RESET);
    cyc(20);
    chk("R2 R4 held in reset by undervoltage", outs(), E_RESET);
    vreg_uv = 1'b0;
    n = 0;
    while (!rstn_o && n < 100) begin cyc(1); n++; end
    chk("R4 pulse after undervoltage", n, RT);
    chk("R4 exit to normal", outs(), E_NORM);

    // R1 supply loss acts before the next clock edge
    vs_below_off = 1'b1; vs_above_on = 1'b0;
    #1;
    chk("R1 immediate outputs", outs(), E_OFF);
    cyc(3);
    vs_below_off = 1'b0; vs_above_on = 1'b1;
    n = 0;
    for (int i = 0; i < 50 && !rstn_o; i++) begin
      cyc(1);
      if (vreg_en && !rstn_o) n++;
    end
    chk("R4 pulse from shutdown", n, RT);
    chk("R4 R9 normal after pulse", outs(), E_NORM);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule